// File: doc/BRIEF.md
# Trigger Decision and Serial Trigger Message Generator

This block turns up to five trigger sources into a single trigger decision and answers each accepted trigger with a 32-bit trigger message sent on one serial line. Four sources are asynchronous level inputs: a three-layer coincidence line, a high-energy calorimeter line, a low-energy calorimeter line and a general-purpose external line. The fifth source is a one-cycle strobe raised by the register decoder whenever software writes the trigger register. A disable-style mask selects the active sources. A throttle input can veto triggers, and a configuration bit tells the block to ignore that veto.

The message has two halves. The upper half is a per-event options word. The lower half holds an event number and a parity bit. The event number is a counter that is seeded at the start of a run. It steps once per accepted message and wraps to zero. Parity polarity is selectable, so software can send bad parity on purpose. Triggers that arrive while a message is still being shifted out are dropped and counted. The block also drives the event-data flow-control line. That line follows a software bit alone, or that bit ORed with a receive-FIFO almost-full flag.

Top module: `trig_msg_gen`

## Requirements
- R1: Source k (0 three-in-a-row, 1 calorimeter high, 2 calorimeter low, 3 external line, 4 software strobe) is disabled when `cfg_i[20+k]` is 1. With `cfg_i[24:20]` all zero, every source can trigger.
- R2: While `throttle_i` is 1, no trigger is accepted unless `cfg_i[18]` is 1. When `cfg_i[18]` is 1, the throttle input has no effect.
- R3: A 0-to-1 change of `cfg_i[19]` loads the run seed: event number `cfg_i[14:0]`, tag `cfg_i[16:15]`, parity select `cfg_i[17]`. Changes to those fields while bit 19 stays high have no effect.
- R4: The first message after a seed load carries the seeded event number. Each accepted message then steps the 17-bit value {tag, event number} by one, and that value wraps from all ones to zero. Message bits [15:1] carry the event number.
- R5: Message bit 0 makes the number of ones in the 32-bit message even when the latched parity select is 1, and odd when it is 0.
- R6: Message bits [31:16] equal `opt_i[15:0]`. The exception: when `opt_i[16]` is 1 and an external source (k = 0..3) caused the trigger, bits 31 (calibration strobe) and 30 (trigger acknowledge) are sent as 0.
- R7: `flow_o` equals `sw_flow_i` when `cfg_i[25]` is 0, and `sw_flow_i | fifo_afull_i` when `cfg_i[25]` is 1.
- R8: An accepted trigger pulses `trig_o` for one cycle and updates `msg_o`. From that cycle on, `ser_o` sends a 1 start bit and then message bits 31 down to 0, one per cycle. `busy_o` is high for exactly those 33 cycles, and `ser_o` is 0 while idle.
- R9: An enabled, unthrottled trigger that arrives while `busy_o` is high is dropped. It does not step the event number, and it increments `drop_cnt_o`, which saturates at 255.
- R10: Each external input passes a two-flop synchronizer and a rising-edge detector. A rising edge yields at most one trigger, however long the input stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 26 | Configuration word: seed, parity select, throttle disable, latch, mask, flow source |
| opt_i | input | 17 | Options: [15:0] upper message half, [16] strip calibration bits on external triggers |
| sw_trig_wr_i | input | 1 | One-cycle strobe on any write to the trigger register |
| ext_trig_i | input | 4 | Asynchronous external trigger lines, index = source number |
| throttle_i | input | 1 | Trigger veto, synchronous to clk |
| sw_flow_i | input | 1 | Software flow-control bit |
| fifo_afull_i | input | 1 | Receive FIFO almost-full flag |
| flow_o | output | 1 | Flow-control output |
| trig_o | output | 1 | One-cycle pulse per accepted trigger |
| msg_o | output | 32 | Last accepted trigger message |
| ser_o | output | 1 | Serial message line |
| busy_o | output | 1 | Message being shifted out |
| drop_cnt_o | output | 8 | Saturating count of dropped triggers |

## Verification
The bound checker watches these rules on every cycle:
- a full mask or an unbypassed throttle stops acceptance;
- a trigger is accepted only from idle, and it starts the start bit at once;
- the line stays low while idle, and the message holds steady while it is sent;
- the drop count never falls;
- both flow-control modes produce the right output.

Only the bench scenarios can show the value-dependent behaviour:
- the seed loads on the rising latch bit and ignores later field changes;
- the event number steps and wraps at 17 bits;
- the parity polarity;
- the calibration bits are stripped only for external causes;
- the exact serial bit order;
- one trigger per held edge;
- the drop counter saturates at 255.

// File: rtl/trig_pkg.sv
// Shared constants for the trigger generator: field positions in the
// configuration and options words, and the widths of the message parts.
package trig_pkg;
    localparam int EXT_SRC_N    = 4;                  // asynchronous trigger lines
    localparam int SRC_N        = EXT_SRC_N + 1;      // plus software strobe
    localparam int HALF_W       = 16;                 // one half of the message
    localparam int MSG_W        = 2 * HALF_W;
    localparam int EVN_W        = 15;                 // event number width
    localparam int TAG_W        = 2;                  // tag width (counter extension)
    localparam int CFG_W        = 26;
    localparam int CFG_TAG_LO   = EVN_W;              // 16:15
    localparam int CFG_PSEL     = 17;
    localparam int CFG_THR_DIS  = 18;
    localparam int CFG_LATCH    = 19;
    localparam int CFG_MASK_LO  = 20;                 // 24:20
    localparam int CFG_FLOW_SRC = 25;
    localparam int OPT_W        = HALF_W + 1;
    localparam int OPT_EXT_RO   = HALF_W;             // strip bit, not sent
    localparam int OPT_CAL      = 15;                 // calibration strobe in upper half
    localparam int OPT_TACK     = 14;                 // trigger acknowledge in upper half
endpackage

// File: rtl/trig_edge_sync.sv
// Brings W asynchronous lines into the clock domain through two flops each
// and emits a one-cycle pulse for every rising edge seen after them.
// Assumes each input stays stable for at least two clock cycles.
module trig_edge_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [2:0] sr;
        // two synchronizer stages plus one history stage for edge detection
        always_ff @(posedge clk) begin
            if (!rst_n) sr <= '0;
            else        sr <= {sr[1:0], async_i[g]};
        end
        assign rise_o[g] = sr[1] & ~sr[2];
    end
endmodule

// File: rtl/trig_evcount.sv
// Event counter with run seed. A 0-to-1 change of latch_i loads
// {tag, event number} and the parity select; step_i then adds one, wrapping
// to zero. Assumes latch_i and step_i are synchronous to clk.
module trig_evcount #(
    parameter int EVN_W = 15,
    parameter int TAG_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             latch_i,
    input  logic [EVN_W-1:0] seed_evn_i,
    input  logic [TAG_W-1:0] seed_tag_i,
    input  logic             seed_psel_i,
    input  logic             step_i,
    output logic [EVN_W-1:0] evn_o,
    output logic             psel_o
);
    localparam int CNT_W = EVN_W + TAG_W;

    logic [CNT_W-1:0] cnt;
    logic             latch_q;

    // history of the latch control bit for rising-edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) latch_q <= 1'b0;
        else        latch_q <= latch_i;
    end

    // seed load on the rising latch bit, otherwise count accepted messages
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt    <= '0;
            psel_o <= 1'b0;
        end else if (latch_i && !latch_q) begin
            cnt    <= {seed_tag_i, seed_evn_i};
            psel_o <= seed_psel_i;
        end else if (step_i) begin
            cnt    <= cnt + 1'b1;
        end
    end

    assign evn_o = cnt[EVN_W-1:0];
endmodule

// File: rtl/trig_serial.sv
// Shifts out a start bit (1) followed by the W-bit word, MSB first, one bit
// per cycle. busy_o is high for the W+1 cycles of the frame. Assumes load_i
// is only raised while busy_o is low.
module trig_serial #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] data_i,
    output logic         ser_o,
    output logic         busy_o
);
    localparam int CW = $clog2(W + 2);

    logic [W:0]    sh;
    logic [CW-1:0] left;

    // frame load and per-cycle shift with a count of bits still on the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh   <= '0;
            left <= '0;
        end else if (load_i) begin
            sh   <= {1'b1, data_i};
            left <= CW'(W + 1);
        end else if (left != '0) begin
            sh   <= {sh[W-1:0], 1'b0};
            left <= left - 1'b1;
        end
    end

    assign busy_o = (left != '0);
    assign ser_o  = busy_o & sh[W];
endmodule

// File: rtl/trig_msg_gen.sv
// Trigger decision, message assembly and serial send. Masks five sources,
// applies the throttle veto, builds the 32-bit message from the options word
// and the event counter, and starts the serializer when it is idle. Busy-time
// triggers are dropped and counted. Also forms the flow-control output.
// Assumes cfg_i, opt_i, throttle_i and sw_trig_wr_i are synchronous to clk.
module trig_msg_gen
    import trig_pkg::*;
#(
    parameter int DROP_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_W-1:0]     cfg_i,
    input  logic [OPT_W-1:0]     opt_i,
    input  logic                 sw_trig_wr_i,
    input  logic [EXT_SRC_N-1:0] ext_trig_i,
    input  logic                 throttle_i,
    input  logic                 sw_flow_i,
    input  logic                 fifo_afull_i,
    output logic                 flow_o,
    output logic                 trig_o,
    output logic [MSG_W-1:0]     msg_o,
    output logic                 ser_o,
    output logic                 busy_o,
    output logic [DROP_W-1:0]    drop_cnt_o
);
    logic [EXT_SRC_N-1:0] ext_rise;
    logic [SRC_N-1:0]     src, armed;
    logic                 thr_ok, req, accept, ext_cause;
    logic [EVN_W-1:0]     evn;
    logic                 psel;
    logic [HALF_W-1:0]    upper;
    logic                 par_raw;
    logic [MSG_W-1:0]     msg_next;

    trig_edge_sync #(.W(EXT_SRC_N)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_trig_i),
        .rise_o  (ext_rise)
    );

    // source gating: software strobe on top, disable-active mask, throttle veto
    assign src       = {sw_trig_wr_i, ext_rise};
    assign armed     = src & ~cfg_i[CFG_MASK_LO +: SRC_N];
    assign thr_ok    = !throttle_i || cfg_i[CFG_THR_DIS];
    assign req       = (|armed) && thr_ok;
    assign accept    = req && !busy_o;
    assign ext_cause = |armed[EXT_SRC_N-1:0];

    trig_evcount #(.EVN_W(EVN_W), .TAG_W(TAG_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .latch_i     (cfg_i[CFG_LATCH]),
        .seed_evn_i  (cfg_i[EVN_W-1:0]),
        .seed_tag_i  (cfg_i[CFG_TAG_LO +: TAG_W]),
        .seed_psel_i (cfg_i[CFG_PSEL]),
        .step_i      (accept),
        .evn_o       (evn),
        .psel_o      (psel)
    );

    // message assembly: options half (stripped on external cause), event number, parity
    always_comb begin
        upper = opt_i[HALF_W-1:0];
        if (ext_cause && opt_i[OPT_EXT_RO]) begin
            upper[OPT_CAL]  = 1'b0;
            upper[OPT_TACK] = 1'b0;
        end
        par_raw  = ^{upper, evn};
        msg_next = {upper, evn, (psel ? par_raw : ~par_raw)};
    end

    // capture of the accepted message and the accept pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_o <= 1'b0;
            msg_o  <= '0;
        end else begin
            trig_o <= accept;
            if (accept) msg_o <= msg_next;
        end
    end

    // saturating count of triggers lost to a busy serializer
    always_ff @(posedge clk) begin
        if (!rst_n)                                  drop_cnt_o <= '0;
        else if (req && busy_o && drop_cnt_o != '1)  drop_cnt_o <= drop_cnt_o + 1'b1;
    end

    trig_serial #(.W(MSG_W)) u_ser (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (accept),
        .data_i (msg_next),
        .ser_o  (ser_o),
        .busy_o (busy_o)
    );

    // flow control: software bit, optionally ORed with FIFO almost-full
    assign flow_o = sw_flow_i | (cfg_i[CFG_FLOW_SRC] & fifo_afull_i);
endmodule

// File: rtl/trig_msg_gen_chk.sv
// Cycle-level rules of trig_msg_gen, bound to every instance of it.
module trig_msg_gen_chk
    import trig_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic [CFG_W-1:0] cfg_i,
    input logic             throttle_i,
    input logic             sw_flow_i,
    input logic             fifo_afull_i,
    input logic             flow_o,
    input logic             trig_o,
    input logic [MSG_W-1:0] msg_o,
    input logic             ser_o,
    input logic             busy_o,
    input logic [7:0]       drop_cnt_o
);
    logic armed_q;

    // marks that at least one out-of-reset cycle has passed, so $past is valid
    always_ff @(posedge clk) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_mask_all_R1: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(cfg_i[CFG_MASK_LO +: SRC_N]) == '1) |-> !trig_o);

    assert_throttle_R2: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(throttle_i) && !$past(cfg_i[CFG_THR_DIS])) |-> !trig_o);

    assert_start_bit_R8: assert property (@(posedge clk) disable iff (!rst_n)
        trig_o |-> (busy_o && ser_o));

    assert_idle_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !ser_o);

    assert_msg_hold_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        (busy_o && !trig_o) |-> $stable(msg_o));

    assert_accept_idle_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        trig_o |-> !$past(busy_o));

    assert_drop_mono_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        drop_cnt_o >= $past(drop_cnt_o));

    assert_flow_sw_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_i[CFG_FLOW_SRC] |-> (flow_o == sw_flow_i));

    assert_flow_full_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_i[CFG_FLOW_SRC] && fifo_afull_i) |-> flow_o);
endmodule

bind trig_msg_gen trig_msg_gen_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_i        (cfg_i),
    .throttle_i   (throttle_i),
    .sw_flow_i    (sw_flow_i),
    .fifo_afull_i (fifo_afull_i),
    .flow_o       (flow_o),
    .trig_o       (trig_o),
    .msg_o        (msg_o),
    .ser_o        (ser_o),
    .busy_o       (busy_o),
    .drop_cnt_o   (drop_cnt_o)
);

// File: tb/sim_trig_msg_gen.sv
// Self-checking bench for trig_msg_gen: sweeps sources against mask patterns,
// parity polarities, option words and counter seeds, with expected values
// computed arithmetically from the requirements.
module sim_trig_msg_gen;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [25:0] cfg = '0;
    logic [16:0] opt = '0;
    logic        sw_wr = 1'b0;
    logic [3:0]  ext = '0;
    logic        throttle = 1'b0;
    logic        sw_flow = 1'b0;
    logic        afull = 1'b0;
    logic        flow_o, trig_o, ser_o, busy_o;
    logic [31:0] msg_o;
    logic [7:0]  drop_o;

    int checks = 0;
    int fails  = 0;
    int fires  = 0;
    logic [31:0] last_msg = '0;
    bit done = 0;

    always #(CLK_P/2) clk = ~clk;

    trig_msg_gen u0 (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .opt_i(opt), .sw_trig_wr_i(sw_wr),
        .ext_trig_i(ext), .throttle_i(throttle), .sw_flow_i(sw_flow),
        .fifo_afull_i(afull), .flow_o(flow_o), .trig_o(trig_o), .msg_o(msg_o),
        .ser_o(ser_o), .busy_o(busy_o), .drop_cnt_o(drop_o)
    );

    // counts accepted triggers and keeps the latest message seen at the ports
    always @(negedge clk) begin
        if (rst_n && trig_o) begin
            fires    = fires + 1;
            last_msg = msg_o;
        end
    end

    task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", rq, act, exp);
        end
    endtask

    task automatic tick(input int n = 1);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] exp_msg(input logic [16:0] o, input bit ext_cause,
                                            input logic [14:0] e, input bit ps);
        logic [15:0] up;
        logic p;
        up = o[15:0];
        if (ext_cause && o[16]) begin up[15] = 1'b0; up[14] = 1'b0; end
        p = ^{up, e};
        return {up, e, (ps ? p : ~p)};
    endfunction

    // drop the latch bit, set the fields, then raise bit 19
    task automatic latch_run(input logic [14:0] evn, input logic [1:0] tag, input bit ps,
                             input bit thr_dis, input logic [4:0] mask);
        cfg = {cfg[25], mask, 1'b0, thr_dis, ps, tag, evn};
        tick();
        cfg[19] = 1'b1;
        tick(2);
    endtask

    // software trigger, then check message, serial frame and busy length
    task automatic int_fire_check(input logic [31:0] exp, input string rq);
        bit ser_ok = 1;
        logic [32:0] frame = '0;
        sw_wr = 1'b1; tick(); sw_wr = 1'b0;
        chk(trig_o === 1'b1, "R8 accept pulse", {31'd0, trig_o}, 32'd1);
        chk(msg_o === exp, rq, msg_o, exp);
        for (int i = 0; i < 33; i++) begin
            frame[32-i] = ser_o;
            if (ser_o !== ((i == 0) ? 1'b1 : exp[32-i]) || busy_o !== 1'b1) ser_ok = 0;
            tick();
        end
        chk(ser_ok, "R8 serial frame", frame[31:0], exp);
        chk(busy_o === 1'b0 && ser_o === 1'b0, "R8 busy ends after 33 cycles",
            {30'd0, busy_o, ser_o}, 32'd0);
        tick();
    endtask

    task automatic pulse_src(input int k);
        if (k == 4) begin sw_wr = 1'b1; tick(); sw_wr = 1'b0; end
        else begin ext[k] = 1'b1; tick(4); ext[k] = 1'b0; end
        tick(40);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        int n0;
        logic [7:0] d0;
        tick(4);
        rst_n = 1'b1;
        tick();
        // reset state
        chk(trig_o === 0 && busy_o === 0 && ser_o === 0, "R8 reset idle",
            {29'd0, trig_o, busy_o, ser_o}, 32'd0);
        chk(drop_o === 8'd0, "R9 reset drop count", {24'd0, drop_o}, 32'd0);

        // R4/R5: counting and both parity polarities with varied options
        for (int ps = 0; ps < 2; ps++) begin
            latch_run(15'h1234, 2'd0, ps[0], 1'b0, 5'd0);
            for (int i = 0; i < 4; i++) begin
                opt = {1'b0, 16'(i * 16'h1357 + ps * 16'h0F0F)};
                int_fire_check(exp_msg(opt, 0, 15'(15'h1234 + i), ps[0]), "R4 R5 R6 message");
            end
        end

        // R3: seed field changes while bit 19 stays high are ignored
        cfg[14:0] = 15'h2222; tick(2);
        int_fire_check(exp_msg(opt, 0, 15'h1238, 1'b1), "R3 no reload while high");
        cfg[19] = 1'b0; tick(); cfg[19] = 1'b1; tick(2);
        int_fire_check(exp_msg(opt, 0, 15'h2222, 1'b1), "R3 reload on rising bit");

        // R4: 17-bit wrap of {tag, event number}
        latch_run(15'h7FFF, 2'd3, 1'b0, 1'b0, 5'd0);
        int_fire_check(exp_msg(opt, 0, 15'h7FFF, 1'b0), "R4 last before wrap");
        int_fire_check(exp_msg(opt, 0, 15'h0000, 1'b0), "R4 wrap to zero");
        int_fire_check(exp_msg(opt, 0, 15'h0001, 1'b0), "R4 after wrap");

        // R1: each source against masks none, own bit, all-but-own
        for (int k = 0; k < 5; k++) begin
            for (int v = 0; v < 3; v++) begin
                logic [4:0] m;
                m = (v == 0) ? 5'd0 : (v == 1) ? 5'(1 << k) : ~5'(1 << k);
                latch_run(15'h0010, 2'd0, 1'b1, 1'b0, m);
                n0 = fires;
                pulse_src(k);
                chk((fires - n0) == (m[k] ? 0 : 1), "R1 mask gating",
                    32'(fires - n0), (m[k] ? 32'd0 : 32'd1));
            end
        end

        // R6: calibration and acknowledge bits stripped only for external causes
        latch_run(15'h0100, 2'd0, 1'b1, 1'b0, 5'd0);
        opt = 17'h1_C0A5;
        pulse_src(1);
        chk(last_msg === exp_msg(opt, 1, 15'h0100, 1'b1), "R6 external strip",
            last_msg, exp_msg(opt, 1, 15'h0100, 1'b1));
        int_fire_check(exp_msg(opt, 0, 15'h0101, 1'b1), "R6 internal keeps bits");
        opt = 17'h0_C0A5;
        pulse_src(3);
        chk(last_msg === exp_msg(opt, 1, 15'h0102, 1'b1), "R6 no strip when option clear",
            last_msg, exp_msg(opt, 1, 15'h0102, 1'b1));

        // R2: throttle veto and its bypass
        throttle = 1'b1;
        n0 = fires;
        pulse_src(4);
        pulse_src(0);
        chk(fires == n0, "R2 throttle vetoes", 32'(fires - n0), 32'd0);
        latch_run(15'h0200, 2'd0, 1'b1, 1'b1, 5'd0);
        n0 = fires;
        pulse_src(2);
        chk(fires - n0 == 1, "R2 throttle ignored", 32'(fires - n0), 32'd1);
        chk(last_msg[15:1] === 15'h0200, "R2 bypass message number", {17'd0, last_msg[15:1]}, 32'h200);
        throttle = 1'b0;

        // R10: long high level gives one trigger
        n0 = fires;
        ext[2] = 1'b1; tick(90); ext[2] = 1'b0; tick(40);
        chk(fires - n0 == 1, "R10 one trigger per edge", 32'(fires - n0), 32'd1);

        // R9: triggers during a frame are dropped and do not count events
        latch_run(15'h0050, 2'd0, 1'b1, 1'b0, 5'd0);
        d0 = drop_o;
        sw_wr = 1'b1; tick(); sw_wr = 1'b0; tick(2);
        for (int i = 0; i < 3; i++) begin sw_wr = 1'b1; tick(); sw_wr = 1'b0; tick(2); end
        tick(40);
        chk(drop_o === d0 + 8'd3, "R9 drop count", {24'd0, drop_o}, {24'd0, d0 + 8'd3});
        int_fire_check(exp_msg(opt, 0, 15'h0051, 1'b1), "R9 dropped not numbered");
        sw_wr = 1'b1; tick(420); sw_wr = 1'b0; tick(40);
        chk(drop_o === 8'hFF, "R9 drop saturation", {24'd0, drop_o}, 32'hFF);

        // R7: flow control in all combinations
        for (int i = 0; i < 8; i++) begin
            cfg[25] = i[2]; sw_flow = i[1]; afull = i[0];
            tick();
            chk(flow_o === (i[1] | (i[2] & i[0])), "R7 flow control",
                {31'd0, flow_o}, {31'd0, (i[1] | (i[2] & i[0]))});
        end

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule